// File: doc/BRIEF.md
# Gapless Lane Framer with Forced Burst Continuation

This block sits on the transmit side of a packet link. Each cycle it can take one 64-bit word from the per-port queues and it produces four 16-bit lanes. The upstream source gives, with each word, a port number, a start-of-packet flag, a last-word flag and the number of valid bytes in that last word. The framer places a 16-bit payload control word ahead of each new packet, each change of port and each forced continuation. A control word also carries the end-of-packet status and the 4-bit diagonal parity of the segment it closes. Control and data words go into one continuous lane stream. When a packet ends part way through a 64-bit word, the next control word goes in the very next lane, so two or more control words can leave in the same cycle. Idle words appear only when the source has nothing to send.

A down-counter limits each segment to `BURST` input words. When the counter runs out and the same packet goes on, the framer inserts a continuation control word (no start, no end status) that carries the parity of the segment just closed. The receiver therefore checks parity at regular points inside long packets. Packets from different ports can be interleaved word by word, because every change of port starts a new segment.

Top module: `gapless_framer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` and `in_ready` are low. From the following cycle, `in_ready` is high while the framer is empty.
- R2: Lanes leave in stream order, with lane 0 in `out_lanes[15:0]` first and lane 3 in `out_lanes[63:48]` last. A data word's 16-bit groups enter the stream starting with `in_data[15:0]`. `out_ctl[i]` is 1 when lane i holds a control word and 0 when it holds data.
- R3: A payload control word has bit 15 = 1, bit 12 = start flag and bits 11:4 = port. It is inserted before an accepted word when that word has its start flag set, or its port differs from the previous accepted word, or the previous word ended a packet, or no segment is open.
- R4: Bits 14:13 of a control word give the status of the packet that ended just before it: 00 not ended, 01 ended with 2 valid bytes in its last lane, 10 ended with 1 valid byte. The code 11 never appears. A last word with B valid bytes (1 to 8) contributes ceil(B/2) lanes.
- R5: While `in_valid` stays high, no all-zero idle word is output. Control words for consecutive segments follow the last data lane with no gap, and several may share one cycle.
- R6: After `BURST` consecutive accepted words in one segment, the next word of the same packet and port is preceded by a continuation control word (bit 15 = 1, bits 14:12 = 000).
- R7: Control word bits 3:0 hold the parity. Start from a zero 16-bit accumulator. For each lane since the previous control word, rotate the accumulator left by one bit and XOR in that lane. Then do the same for the current control word with bits 3:0 set to 1111. The parity is the XOR of the four nibbles of the result.
- R8: When `in_valid` is low and a packet has ended without a following control word, a closing idle word is output. It has bit 15 = 0, bits 14:13 = end status, bits 12:4 = 0 and bits 3:0 = parity by the R7 rule. Once no segment is open, leftover lanes go out at once, and the rest of that cycle is filled with all-zero control lanes.
- R9: While a packet is open and `in_valid` is low, no lanes are invented. `in_ready` goes low only when more than `DEPTH`-5 lanes are held, and in that case a full cycle of lanes is output on the next cycle. No accepted lane is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a word this cycle |
| in_data | input | 64 | Four 16-bit groups, the group in bits 15:0 first |
| in_port | input | PORT_W | Port of the offered word |
| in_sop | input | 1 | Word starts a packet |
| in_last | input | 1 | Word ends a packet |
| in_bytes | input | 4 | Valid bytes in a last word, 1 to 8 |
| in_ready | output | 1 | Framer takes a word offered this cycle |
| out_valid | output | 1 | Four lanes are present |
| out_lanes | output | 64 | Four 16-bit lanes, lane 0 in bits 15:0 |
| out_ctl | output | 4 | Per-lane control-word flag |

## Verification
Runs of short back-to-back packets with odd byte counts, kept up without a break, show whether end status is merged into the next start word, whether several control words pack into one cycle, and whether the queue throttles `in_ready` without losing lanes. A single long packet on one port exercises the forced continuation and its interim parity. A source that goes idle after a packet shows the closing idle word and the padding. Word-by-word interleaving of two ports, and a packet with idle gaps in its middle, separate a port-change insertion from a start insertion and show that a stall does not flush partial lanes.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef logic [15:0] word_t;

  typedef struct packed {
    logic  is_ctl;
    word_t w;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  localparam logic [1:0] EOP_NONE = 2'b00;
  localparam logic [1:0] EOP_TWO  = 2'b01;
  localparam logic [1:0] EOP_ONE  = 2'b10;

  function automatic word_t rotl1(input word_t a);
    return {a[14:0], a[15]};
  endfunction

  function automatic logic [3:0] fold4(input word_t a);
    return a[15:12] ^ a[11:8] ^ a[7:4] ^ a[3:0];
  endfunction
endpackage

// File: rtl/gf_dip.sv
module gf_dip
  import gf_pkg::*;
(
  input  word_t       acc_in,
  input  word_t       cw_in,
  input  logic        restart,
  input  logic [63:0] data_in,
  input  logic [2:0]  nwords,
  output logic [3:0]  dip,
  output word_t       acc_out
);
  // parity closing the current segment, control word included
  assign dip = fold4(rotl1(acc_in) ^ cw_in);

  // accumulate the data lanes of this cycle into the (possibly new) segment
  always_comb begin
    word_t a;
    a = restart ? '0 : acc_in;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < nwords) a = rotl1(a) ^ data_in[16*i +: 16];
    end
    acc_out = a;
  end
endmodule

// File: rtl/gf_lane_queue.sv
module gf_lane_queue
  import gf_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          app_n,
  input  logic [5*SLOT_W-1:0] app_vec,
  input  logic                pad_ok,
  output logic                out_valid,
  output logic [63:0]         out_lanes,
  output logic [3:0]          out_ctl,
  output logic                ready
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LIMIT = DEPTH - 5;

  slot_t             mem [DEPTH];
  slot_t             tmp [DEPTH];
  slot_t             nmem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  int                total, ncnt;
  logic              emit;
  logic [63:0]       lanes_n;
  logic [3:0]        ctl_n;

  always_comb begin
    total = int'(cnt) + int'(app_n);
    for (int j = 0; j < DEPTH; j++) begin
      tmp[j] = mem[j];
      if (j >= int'(cnt) && j < total) tmp[j] = slot_t'(app_vec[(j - int'(cnt))*SLOT_W +: SLOT_W]);
    end
    emit    = (total >= 4) || (pad_ok && total > 0);
    lanes_n = '0;
    ctl_n   = '0;
    for (int i = 0; i < 4; i++) begin
      if (emit) begin
        lanes_n[16*i +: 16] = (i < total) ? tmp[i].w : 16'h0000;
        ctl_n[i]            = (i < total) ? tmp[i].is_ctl : 1'b1;
      end
    end
    for (int j = 0; j < DEPTH; j++) begin
      if (total >= 4)  nmem[j] = (j + 4 < DEPTH) ? tmp[(j + 4) % DEPTH] : '0;
      else if (emit)   nmem[j] = '0;
      else             nmem[j] = tmp[j];
    end
    if (total >= 4)  ncnt = total - 4;
    else if (emit)   ncnt = 0;
    else             ncnt = total;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) mem[j] <= nmem[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ready     <= 1'b0;
      out_valid <= 1'b0;
      out_lanes <= '0;
      out_ctl   <= '0;
    end else begin
      cnt       <= CNT_W'(ncnt);
      ready     <= (ncnt <= LIMIT);
      out_valid <= emit;
      out_lanes <= lanes_n;
      out_ctl   <= ctl_n;
    end
  end
endmodule

// File: rtl/gapless_framer.sv
module gapless_framer
  import gf_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int BURST  = 4,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       in_data,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_sop,
  input  logic              in_last,
  input  logic [3:0]        in_bytes,
  output logic              in_ready,
  output logic              out_valid,
  output logic [63:0]       out_lanes,
  output logic [3:0]        out_ctl
);
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;

  logic              seg_open;
  logic [1:0]        eop_pend;
  logic [PORT_W-1:0] cur_port;
  logic [BW-1:0]     bcnt;
  word_t             acc;

  logic              accept, need_cw, close_seg, pad_ok;
  logic [2:0]        nwords, app_n;
  word_t             cw_raw, cw_fin, acc_next;
  logic [3:0]        dip;
  logic [5*SLOT_W-1:0] app_vec;

  assign accept    = in_valid && in_ready;
  assign close_seg = !in_valid && (eop_pend != EOP_NONE);
  assign need_cw   = in_sop || !seg_open || (eop_pend != EOP_NONE) ||
                     (in_port != cur_port) || (bcnt == '0);
  assign nwords    = in_last ? 3'((in_bytes + 4'd1) >> 1) : 3'd4;
  assign cw_raw    = accept ? {1'b1, eop_pend, in_sop, 8'(in_port), 4'hF}
                            : {1'b0, eop_pend, 1'b0, 8'h00, 4'hF};
  assign cw_fin    = {cw_raw[15:4], dip};
  assign pad_ok    = !in_valid && (close_seg || !seg_open);

  gf_dip u_dip (
    .acc_in  (acc),
    .cw_in   (cw_raw),
    .restart (need_cw),
    .data_in (in_data),
    .nwords  (nwords),
    .dip     (dip),
    .acc_out (acc_next)
  );

  always_comb begin
    app_vec = '0;
    app_n   = 3'd0;
    if (accept) begin
      if (need_cw) begin
        app_vec[0 +: SLOT_W] = {1'b1, cw_fin};
        for (int i = 0; i < 4; i++) app_vec[(i+1)*SLOT_W +: SLOT_W] = {1'b0, in_data[16*i +: 16]};
        app_n = nwords + 3'd1;
      end else begin
        for (int i = 0; i < 4; i++) app_vec[i*SLOT_W +: SLOT_W] = {1'b0, in_data[16*i +: 16]};
        app_n = nwords;
      end
    end else if (close_seg) begin
      app_vec[0 +: SLOT_W] = {1'b1, cw_fin};
      app_n = 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_open <= 1'b0;
      eop_pend <= EOP_NONE;
      cur_port <= '0;
      bcnt     <= '0;
      acc      <= '0;
    end else if (accept) begin
      seg_open <= 1'b1;
      cur_port <= in_port;
      acc      <= acc_next;
      bcnt     <= need_cw ? BW'(BURST - 1) : bcnt - BW'(1);
      eop_pend <= !in_last ? EOP_NONE : (in_bytes[0] ? EOP_ONE : EOP_TWO);
    end else if (close_seg) begin
      seg_open <= 1'b0;
      eop_pend <= EOP_NONE;
      acc      <= '0;
    end
  end

  gf_lane_queue #(.DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .app_n     (app_n),
    .app_vec   (app_vec),
    .pad_ok    (pad_ok),
    .out_valid (out_valid),
    .out_lanes (out_lanes),
    .out_ctl   (out_ctl),
    .ready     (in_ready)
  );
endmodule

// File: rtl/gf_checker.sv
module gf_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic [63:0] out_lanes,
  input logic [3:0]  out_ctl
);
  for (genvar i = 0; i < 4; i++) begin : g_lane
    // R4
    eop_code_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ctl[i] && out_lanes[16*i+15]) |-> (out_lanes[16*i+13 +: 2] != 2'b11));
    // R8
    idle_word_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ctl[i] && !out_lanes[16*i+15]) |-> (out_lanes[16*i+4 +: 9] == 9'd0));
    // R5
    no_pad_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ctl[i] && out_lanes[16*i +: 16] == 16'h0000) |-> !$past(in_valid));
  end

  // R9
  drain_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !$past(rst)) |=> out_valid);
endmodule

bind gapless_framer gf_checker u_gf_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_lanes (out_lanes),
  .out_ctl   (out_ctl)
);

// File: tb/tb_gapless_framer.sv
module tb_gapless_framer;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 8;
  localparam int BURST  = 4;
  localparam int DEPTH  = 12;

  typedef struct {
    bit          idle;
    logic [63:0] data;
    logic [7:0]  port;
    bit          sop;
    bit          last;
    int          bytes;
  } beat_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_last = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic [PORT_W-1:0] in_port = '0;
  logic [3:0] in_bytes = 4'd8;
  logic out_valid;
  logic [63:0] out_lanes;
  logic [3:0] out_ctl;

  gapless_framer #(.PORT_W(PORT_W), .BURST(BURST), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_port(in_port),
    .in_sop(in_sop), .in_last(in_last), .in_bytes(in_bytes), .in_ready(in_ready),
    .out_valid(out_valid), .out_lanes(out_lanes), .out_ctl(out_ctl));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  beat_t beats[$];

  // reference model state
  logic [16:0] mq[$];
  bit m_seg; logic [1:0] m_eop; logic [7:0] m_port; int m_bcnt; logic [15:0] m_acc;
  bit e_valid, e_ready; logic [63:0] e_lanes; logic [3:0] e_ctl; bit e_rst;

  // feature observation
  int seen_multi = 0, seen_cont = 0, seen_odd = 0, seen_close = 0, seen_stall = 0, seen_pad = 0;

  function automatic logic [15:0] rl(logic [15:0] a); return {a[14:0], a[15]}; endfunction
  function automatic logic [3:0] fd(logic [15:0] a); return a[15:12]^a[11:8]^a[7:4]^a[3:0]; endfunction

  task automatic add_beat(logic [7:0] p, bit s, bit l, int b);
    beat_t x;
    x.idle = 0; x.port = p; x.sop = s; x.last = l; x.bytes = b;
    x.data = {$urandom, $urandom};
    beats.push_back(x);
  endtask

  task automatic add_idle(int n);
    for (int k = 0; k < n; k++) begin
      beat_t x;
      x.idle = 1; x.data = '0; x.port = 0; x.sop = 0; x.last = 0; x.bytes = 8;
      beats.push_back(x);
    end
  endtask

  task automatic add_xfer(logic [7:0] p, int bytes);
    int n;
    n = (bytes + 7) / 8;
    for (int k = 0; k < n; k++)
      add_beat(p, k == 0, k == n-1, (k == n-1) ? bytes - 8*(n-1) : 8);
  endtask

  task automatic model_step(bit r, bit valid, bit acc_ok, beat_t b);
    logic [15:0] cw;
    int nw;
    bit need;
    e_rst = r;
    if (r) begin
      mq.delete(); m_seg = 0; m_eop = 0; m_port = 0; m_bcnt = 0; m_acc = 0;
      e_valid = 0; e_lanes = 0; e_ctl = 0; e_ready = 0;
      return;
    end
    if (acc_ok) begin
      need = b.sop || !m_seg || m_eop != 0 || b.port != m_port || m_bcnt == 0;
      nw = b.last ? (b.bytes + 1) / 2 : 4;
      if (need) begin
        cw = {1'b1, m_eop, b.sop, b.port, 4'hF};
        mq.push_back({1'b1, cw[15:4], fd(rl(m_acc) ^ cw)});
        m_acc = 0; m_bcnt = BURST - 1;
      end else m_bcnt--;
      for (int i = 0; i < nw; i++) begin
        m_acc = rl(m_acc) ^ b.data[16*i +: 16];
        mq.push_back({1'b0, b.data[16*i +: 16]});
      end
      m_seg = 1; m_port = b.port;
      m_eop = !b.last ? 2'b00 : ((b.bytes % 2) ? 2'b10 : 2'b01);
    end else if (!valid && m_eop != 0) begin
      cw = {1'b0, m_eop, 1'b0, 8'h00, 4'hF};
      mq.push_back({1'b1, cw[15:4], fd(rl(m_acc) ^ cw)});
      m_eop = 0; m_seg = 0; m_acc = 0;
    end
    e_lanes = 0; e_ctl = 0; e_valid = 0;
    if (mq.size() >= 4 || (!valid && !m_seg && mq.size() > 0)) begin
      e_valid = 1;
      for (int i = 0; i < 4; i++) begin
        logic [16:0] s;
        s = (mq.size() > 0) ? mq.pop_front() : 17'h10000;
        e_lanes[16*i +: 16] = s[15:0];
        e_ctl[i] = s[16];
      end
    end
    e_ready = (mq.size() <= DEPTH - 5);
  endtask

  task automatic compare();
    int npay;
    checks++;
    if (out_valid !== e_valid || out_lanes !== e_lanes || out_ctl !== e_ctl) begin
      fails++;
      if (e_rst) $display("FAIL R1 cycle %0d valid %b lanes %h exp valid %b lanes %h", cyc, out_valid, out_lanes, e_valid, e_lanes);
      else $display("FAIL R2/R3/R7 cycle %0d valid %b lanes %h ctl %b exp valid %b lanes %h ctl %b",
                    cyc, out_valid, out_lanes, out_ctl, e_valid, e_lanes, e_ctl);
    end
    checks++;
    if (in_ready !== e_ready) begin
      fails++;
      $display("FAIL R9 cycle %0d in_ready %b exp %b", cyc, in_ready, e_ready);
    end
    if (out_valid) begin
      npay = 0;
      for (int i = 0; i < 4; i++) begin
        logic [15:0] w;
        w = out_lanes[16*i +: 16];
        if (out_ctl[i] && w[15]) begin
          npay++;
          if (w[14:12] == 3'b000 && !in_valid_was_sop_boundary(w)) seen_cont++;
          if (w[14:13] == 2'b10) seen_odd++;
        end
        if (out_ctl[i] && !w[15] && w != 0) seen_close++;
        if (out_ctl[i] && w == 0) seen_pad++;
      end
      if (npay >= 2) seen_multi++;
    end
    if (!in_ready && !rst) seen_stall++;
  endtask

  // a continuation word: payload, no start, no end status, on the long-packet port 9
  function automatic bit in_valid_was_sop_boundary(logic [15:0] w);
    return w[11:4] != 8'd9;
  endfunction

  task automatic report(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    // R5 / R4 / R9: back-to-back short packets, odd lengths, queue fills
    add_xfer(8'd1, 8); add_xfer(8'd2, 5); add_xfer(8'd3, 3); add_xfer(8'd4, 16);
    add_xfer(8'd5, 1); add_xfer(8'd6, 7); add_xfer(8'd7, 24);
    for (int k = 0; k < 10; k++) add_xfer(8'(10 + k), 8);
    // R8: source idle after a packet
    add_idle(4);
    add_xfer(8'd2, 13);
    add_idle(3);
    // R6: one long packet on port 9
    add_xfer(8'd9, 100);
    add_idle(3);
    // R3: word-by-word interleave of ports 3 and 5
    add_beat(8'd3, 1, 0, 8); add_beat(8'd5, 1, 0, 8);
    add_beat(8'd3, 0, 1, 6); add_beat(8'd5, 0, 1, 3);
    add_idle(3);
    // R9: stalls inside an open packet
    add_beat(8'd4, 1, 0, 8); add_idle(2);
    add_beat(8'd4, 0, 0, 8); add_idle(3);
    add_beat(8'd4, 0, 1, 2);
    add_idle(6);

    begin
      beat_t z;
      z.idle = 1; z.data = 0; z.port = 0; z.sop = 0; z.last = 0; z.bytes = 8;
      model_step(1, 0, 0, z);
    end
    while (beats.size() > 0 || cyc < 8) begin
      beat_t b;
      bit acc_ok;
      @(negedge clk);
      compare();   // R1 while in reset
      cyc++;
      rst = (cyc < 4);
      b.idle = 1; b.data = 0; b.port = 0; b.sop = 0; b.last = 0; b.bytes = 8;
      if (!rst && beats.size() > 0) b = beats[0];
      in_valid = !rst && !b.idle;
      in_data  = b.data; in_port = b.port; in_sop = b.sop; in_last = b.last;
      in_bytes = 4'(b.bytes);
      acc_ok = in_valid && in_ready;
      model_step(rst, in_valid, acc_ok, b);
      if (!rst && beats.size() > 0 && (b.idle || acc_ok)) void'(beats.pop_front());
    end
    in_valid = 0;
    for (int k = 0; k < 10; k++) begin
      beat_t z;
      z.idle = 1; z.data = 0; z.port = 0; z.sop = 0; z.last = 0; z.bytes = 8;
      @(negedge clk); compare(); cyc++;
      model_step(0, 0, 0, z);
    end
    @(negedge clk); compare();

    report("R5 several control words in one cycle", seen_multi > 0, seen_multi, 1);
    report("R6 continuation word on long packet", seen_cont > 0, seen_cont, 1);
    report("R4 one-byte end status seen", seen_odd > 0, seen_odd, 1);
    report("R8 closing idle word seen", seen_close > 0, seen_close, 1);
    report("R8 idle padding seen", seen_pad > 0, seen_pad, 1);
    report("R9 ready throttled", seen_stall > 0, seen_stall, 1);
    report("R2 model queue drained", mq.size() == 0, mq.size(), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual %0d expected 0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end
endmodule